// File: doc/BRIEF.md
# RGB Channel Latch with Group Reordering

This block sits behind a 24-bit serial shift register in an LED panel driver. On a latch command it takes the shifted word, splits it into three 8-bit segments and assigns the segments to the red, green and blue channel groups. The assignment follows a colour sequence chosen by a 3-bit configuration code.

Each colour group has its own active-low output enable. While a group's enable is low, its channels show the latched bits. When the optional staggered start is in use, the channels come on one index at a time, and each step is paced by an external single-cycle tick.

When auto power-off is armed and an all-zero word is latched, the block signals sleep. It then accepts nothing except a latch that turns at least one channel on.

Top module: `led_group_latch`

## Requirements
- R1: After reset every channel output is 0, `sleep_o` is 0, the latched data is all zeros, the colour code is 0, staggering is on and auto power-off is off.
- R2: With colour code 0 (RGB), a latch maps `word_i[23:16]` to red, `word_i[15:8]` to green and `word_i[7:0]` to blue. The most significant bit of each segment is channel 8 (bit 7 of the group output) and the least significant bit is channel 1 (bit 0). The first bit shifted in is `word_i[23]`.
- R3: Colour codes 1 to 5 give the group sequences GBR, GRB, BGR, BRG and RBG. The first letter of the sequence receives `word_i[23:16]`, the second receives `word_i[15:8]` and the third receives `word_i[7:0]`.
- R4: Colour codes 6 and 7 map the word exactly as code 0 does.
- R5: While a group's enable bit is high, that group's outputs are all 0. While the bit is low, the outputs show the latched bits, gated by R6. Enable bit 0 belongs to red, bit 1 to green and bit 2 to blue.
- R6: With staggering on, channel n of a group becomes active once n-1 ticks have been counted since that group's enable went low. Channel 1 is active at once. The count stops at 7, and it restarts from 0 whenever the enable goes high.
- R7: With `cfg_no_stagger_i` written as 1, all channels of an enabled group show their latched bits together, with no tick needed.
- R8: The latched data changes only on a latch command. Changes on `word_i` between latches have no effect on the outputs.
- R9: With auto power-off armed, latching an all-zero word raises `sleep_o` one clock later. Latching a word with any bit set clears `sleep_o` and loads the word.
- R10: While `sleep_o` is high, configuration writes and all-zero latches are ignored.
- R11: With auto power-off disarmed, latching an all-zero word leaves `sleep_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Write the three configuration fields |
| cfg_order_i | input | 3 | Colour sequence code |
| cfg_no_stagger_i | input | 1 | 1 switches all channels together |
| cfg_auto_off_i | input | 1 | 1 arms auto power-off |
| word_i | input | 24 | Shift register contents, bit 23 shifted in first |
| latch_i | input | 1 | Latch command, one cycle |
| oe_n_i | input | 3 | Active-low group enables (B, G, R) |
| tick_i | input | 1 | Stagger step tick, one cycle |
| ch_r_o | output | 8 | Red channel on/off, bit k is channel k+1 |
| ch_g_o | output | 8 | Green channel on/off |
| ch_b_o | output | 8 | Blue channel on/off |
| sleep_o | output | 1 | Auto power-off active |

## Verification
Latch, configuration write and tick effects are all registered, so each one is visible one rising edge after the command is applied. Enable gating is combinational from the registered state, so a change on `oe_n_i` shows in the same cycle. The bench changes inputs on the falling edge. It samples latch, tick and sleep results on the next falling edge, after exactly one rising edge. It samples enable effects one time unit after the change, with no edge in between.

// File: rtl/led_latch_pkg.sv
package led_latch_pkg;

    localparam int N_GRP = 3;

    typedef struct packed {
        logic [2:0] order;
        logic       no_stagger;
        logic       auto_off;
    } cfg_t;

    // Group index (0 red, 1 green, 2 blue) found at stream position pos.
    function automatic logic [1:0] group_at(input logic [2:0] code, input int pos);
        logic [1:0] a, b, c;
        case (code)
            3'd1:    begin a = 2'd1; b = 2'd2; c = 2'd0; end
            3'd2:    begin a = 2'd1; b = 2'd0; c = 2'd2; end
            3'd3:    begin a = 2'd2; b = 2'd1; c = 2'd0; end
            3'd4:    begin a = 2'd2; b = 2'd0; c = 2'd1; end
            3'd5:    begin a = 2'd0; b = 2'd2; c = 2'd1; end
            default: begin a = 2'd0; b = 2'd1; c = 2'd2; end
        endcase
        case (pos)
            0:       return a;
            1:       return b;
            default: return c;
        endcase
    endfunction

endpackage

// File: rtl/grp_order_map.sv
module grp_order_map
    import led_latch_pkg::*;
#(
    parameter int GRP_W = 8,
    localparam int WORD_W = N_GRP * GRP_W
) (
    input  logic [WORD_W-1:0]            word_i,
    input  logic [2:0]                   code_i,
    output logic [N_GRP-1:0][GRP_W-1:0]  grp_o
);

    // Stream position p occupies segment (N_GRP-1-p), the earliest bits on top.
    always_comb begin
        grp_o = '0;
        for (int p = 0; p < N_GRP; p++) begin
            grp_o[group_at(code_i, p)] = word_i[(N_GRP-1-p)*GRP_W +: GRP_W];
        end
    end

endmodule

// File: rtl/stagger_ctrl.sv
module stagger_ctrl #(
    parameter int GRP_W = 8,
    localparam int STEP_W = (GRP_W > 1) ? $clog2(GRP_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oe_n_i,
    input  logic             tick_i,
    input  logic             bypass_i,
    input  logic [GRP_W-1:0] data_i,
    output logic [GRP_W-1:0] ch_o
);

    localparam logic [STEP_W-1:0] STEP_MAX = STEP_W'(GRP_W - 1);

    typedef struct packed {
        logic [STEP_W-1:0] step;
    } st_t;

    st_t s_d, s_q;
    logic [GRP_W-1:0] mask;

    always_comb begin
        s_d = s_q;
        if (oe_n_i) begin
            s_d.step = '0;
        end else if (tick_i && (s_q.step != STEP_MAX)) begin
            s_d.step = s_q.step + STEP_W'(1);
        end
        for (int k = 0; k < GRP_W; k++) begin
            mask[k] = bypass_i | (STEP_W'(k) <= s_q.step);
        end
        ch_o = data_i & mask & {GRP_W{~oe_n_i}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R6: enable high restarts the schedule
    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |=> (s_q.step == '0));
    // R6: each tick while enabled advances one step
    p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n_i && tick_i && (s_q.step != STEP_MAX)) |=> (s_q.step == $past(s_q.step) + STEP_W'(1)));
    // R6: the count holds at its last step
    p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n_i && (s_q.step == STEP_MAX)) |=> (s_q.step == STEP_MAX));

endmodule

// File: rtl/led_group_latch.sv
module led_group_latch
    import led_latch_pkg::*;
#(
    parameter int GRP_W = 8,
    localparam int WORD_W = N_GRP * GRP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_i,
    input  logic [2:0]        cfg_order_i,
    input  logic              cfg_no_stagger_i,
    input  logic              cfg_auto_off_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              latch_i,
    input  logic [N_GRP-1:0]  oe_n_i,
    input  logic              tick_i,
    output logic [GRP_W-1:0]  ch_r_o,
    output logic [GRP_W-1:0]  ch_g_o,
    output logic [GRP_W-1:0]  ch_b_o,
    output logic              sleep_o
);

    typedef struct packed {
        logic [N_GRP-1:0][GRP_W-1:0] data;
        cfg_t                        cfg;
        logic                        sleep;
    } state_t;

    state_t s_d, s_q;
    logic [N_GRP-1:0][GRP_W-1:0] mapped;
    logic [N_GRP-1:0][GRP_W-1:0] ch_all;

    grp_order_map #(.GRP_W(GRP_W)) u_map (
        .word_i (word_i),
        .code_i (s_q.cfg.order),
        .grp_o  (mapped)
    );

    always_comb begin
        s_d = s_q;
        if (cfg_wr_i && !s_q.sleep) begin
            s_d.cfg.order      = cfg_order_i;
            s_d.cfg.no_stagger = cfg_no_stagger_i;
            s_d.cfg.auto_off   = cfg_auto_off_i;
        end
        if (latch_i) begin
            if (word_i != '0) begin
                s_d.data  = mapped;
                s_d.sleep = 1'b0;
            end else if (!s_q.sleep) begin
                s_d.data  = '0;
                s_d.sleep = s_q.cfg.auto_off;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        stagger_ctrl #(.GRP_W(GRP_W)) u_stag (
            .clk      (clk),
            .rst_n    (rst_n),
            .oe_n_i   (oe_n_i[g]),
            .tick_i   (tick_i),
            .bypass_i (s_q.cfg.no_stagger),
            .data_i   (s_q.data[g]),
            .ch_o     (ch_all[g])
        );
    end

    assign ch_r_o  = ch_all[0];
    assign ch_g_o  = ch_all[1];
    assign ch_b_o  = ch_all[2];
    assign sleep_o = s_q.sleep;

    // R2: a latch keeps every set bit of the word
    p_bits_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        latch_i |=> ($countones(s_q.data) == $countones($past(word_i))));
    // R8: no latch, no change of latched data
    p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_i |=> $stable(s_q.data));
    // R9: a non-zero latch wakes the block
    p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_i && (word_i != '0)) |=> !sleep_o);
    // R9: armed and zero latch while awake enters sleep
    p_enter_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_i && (word_i == '0) && s_q.cfg.auto_off) |=> sleep_o);
    // R10: configuration frozen during sleep
    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |=> $stable(s_q.cfg));
    // R11: disarmed and awake stays awake
    p_no_sleep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.cfg.auto_off && !sleep_o && !(cfg_wr_i && cfg_auto_off_i)) |=> !sleep_o);

endmodule

// File: tb/led_group_latch_bench.sv
module led_group_latch_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_i = 1'b0;
    logic [2:0]  cfg_order_i = '0;
    logic        cfg_no_stagger_i = 1'b0;
    logic        cfg_auto_off_i = 1'b0;
    logic [23:0] word_i = '0;
    logic        latch_i = 1'b0;
    logic [2:0]  oe_n_i = 3'b111;
    logic        tick_i = 1'b0;
    logic [7:0]  ch_r_o, ch_g_o, ch_b_o;
    logic        sleep_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    led_group_latch u_led_group_latch (
        .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr_i), .cfg_order_i(cfg_order_i),
        .cfg_no_stagger_i(cfg_no_stagger_i), .cfg_auto_off_i(cfg_auto_off_i),
        .word_i(word_i), .latch_i(latch_i), .oe_n_i(oe_n_i), .tick_i(tick_i),
        .ch_r_o(ch_r_o), .ch_g_o(ch_g_o), .ch_b_o(ch_b_o), .sleep_o(sleep_o)
    );

    function automatic logic [7:0] exp_grp(input logic [23:0] w, input int code, input int g);
        string seq;
        byte want;
        case (code)
            1: seq = "GBR";
            2: seq = "GRB";
            3: seq = "BGR";
            4: seq = "BRG";
            5: seq = "RBG";
            default: seq = "RGB";
        endcase
        want = (g == 0) ? "R" : (g == 1) ? "G" : "B";
        exp_grp = 8'h00;
        for (int p = 0; p < 3; p++) begin
            if (seq[p] == want) exp_grp = w[(2-p)*8 +: 8];
        end
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step_clk();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_cfg(input logic [2:0] ord, input logic nostag, input logic auto_off);
        cfg_order_i = ord; cfg_no_stagger_i = nostag; cfg_auto_off_i = auto_off;
        cfg_wr_i = 1'b1;
        step_clk();
        cfg_wr_i = 1'b0;
    endtask

    task automatic do_latch(input logic [23:0] w);
        word_i = w; latch_i = 1'b1;
        step_clk();
        latch_i = 1'b0;
    endtask

    task automatic check_map(input string req, input logic [23:0] w, input int code);
        check(req, ch_r_o, exp_grp(w, code, 0));
        check(req, ch_g_o, exp_grp(w, code, 1));
        check(req, ch_b_o, exp_grp(w, code, 2));
    endtask

    task automatic t_reset();
        oe_n_i = 3'b000;
        #1;
        check("R1 red", ch_r_o, 8'h00);
        check("R1 green", ch_g_o, 8'h00);
        check("R1 blue", ch_b_o, 8'h00);
        check("R1 sleep", {7'd0, sleep_o}, 8'h00);
        @(negedge clk);
    endtask

    task automatic t_orders();
        logic [23:0] w;
        w = 24'hA5_3C_81;
        do_cfg(3'd0, 1'b1, 1'b0);
        do_latch(w);
        check_map("R2 rgb", w, 0);
        for (int c = 1; c < 6; c++) begin
            do_cfg(3'(c), 1'b1, 1'b0);
            do_latch(w);
            check_map("R3 order", w, c);
        end
        w = 24'h5A_0F_E1;
        for (int c = 6; c < 8; c++) begin
            do_cfg(3'(c), 1'b1, 1'b0);
            do_latch(w);
            check_map("R4 fallback", w, 0);
        end
    endtask

    task automatic t_hold_and_enable();
        do_cfg(3'd0, 1'b1, 1'b0);
        do_latch(24'h11_22_33);
        word_i = 24'hFF_FF_FF;
        step_clk();
        check_map("R8 hold", 24'h11_22_33, 0);
        oe_n_i = 3'b010;
        #1;
        check("R5 red on", ch_r_o, 8'h11);
        check("R5 green off", ch_g_o, 8'h00);
        check("R5 blue on", ch_b_o, 8'h33);
        oe_n_i = 3'b111;
        #1;
        check("R5 all off", ch_r_o | ch_g_o | ch_b_o, 8'h00);
        @(negedge clk);
        oe_n_i = 3'b000;
        #1;
        check_map("R7 together", 24'h11_22_33, 0);
        @(negedge clk);
    endtask

    task automatic t_stagger();
        logic [7:0] exp;
        do_cfg(3'd0, 1'b0, 1'b0);
        oe_n_i = 3'b111;
        do_latch(24'hFF_FF_FF);
        oe_n_i = 3'b000;
        #1;
        check("R6 step0", ch_r_o, 8'h01);
        @(negedge clk);
        for (int i = 1; i <= 9; i++) begin
            tick_i = 1'b1;
            step_clk();
            tick_i = 1'b0;
            exp = (i >= 7) ? 8'hFF : 8'((1 << (i + 1)) - 1);
            check("R6 red step", ch_r_o, exp);
            check("R6 blue step", ch_b_o, exp);
        end
        step_clk();
        check("R6 no tick hold", ch_g_o, 8'hFF);
        oe_n_i = 3'b111;
        step_clk();
        oe_n_i = 3'b000;
        #1;
        check("R6 restart", ch_g_o, 8'h01);
        @(negedge clk);
    endtask

    task automatic t_sleep();
        do_cfg(3'd0, 1'b1, 1'b0);
        do_latch(24'h00_00_00);
        check("R11 no sleep", {7'd0, sleep_o}, 8'h00);
        do_cfg(3'd0, 1'b1, 1'b1);
        do_latch(24'h00_00_00);
        check("R9 enter", {7'd0, sleep_o}, 8'h01);
        check("R9 outputs off", ch_r_o | ch_g_o | ch_b_o, 8'h00);
        do_cfg(3'd3, 1'b0, 1'b0);
        do_latch(24'h00_00_00);
        check("R10 still asleep", {7'd0, sleep_o}, 8'h01);
        do_latch(24'h80_40_02);
        check("R9 wake", {7'd0, sleep_o}, 8'h00);
        check_map("R10 cfg ignored", 24'h80_40_02, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_orders();
        t_hold_and_enable();
        t_stagger();
        t_sleep();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule